// File: doc/BRIEF.md
# Extended Mode Register Load Sequencer

This block turns a set of configuration fields from a memory controller into a load-mode command for the extended mode register of a DDR2-style memory device. The fields are DLL disable, reduced drive strength, termination value, additive latency, OCD mode, DQS# disable, RDQS enable and output disable. They are scattered over the address bus, and the block packs them into their bit positions. It checks the latency and OCD codes, and it waits until every bank is idle and no burst is running. It then drives the register-select bits and the packed word for one cycle with the load-mode command. After that it holds itself busy for the mode-register delay.

An initialization request runs two loads, one after the other. The first load carries the OCD field as all ones, which selects the default calibration. The second carries the same fields with the OCD field as all zeros, which exits OCD. The tMRD delay is observed after each load.

Top module: `emr_loader`

## Requirements
- R1: During reset and after it, the command outputs show NOP, `busy_o` and `err_o` are 0, and `ba_o` and `addr_o` are 0.
- R2: In a load cycle, `addr_o` bit 0 = DLL disable, bit 1 = reduced drive, bits 5:3 = additive latency (binary), bits 9:7 = OCD mode, bit 10 = DQS# disable, bit 11 = RDQS enable, bit 12 = output disable.
- R3: Termination `odt_sel_i` (00 off, 01 75 ohm, 10 150 ohm, 11 50 ohm) is placed with its bit 1 on `addr_o` bit 6 and its bit 0 on `addr_o` bit 2.
- R4: In a load cycle, `ba_o` = 3'b001 (extended register select, bank bit 2 at 0) and every `addr_o` bit above 12 is 0.
- R5: A load is a single-cycle strobe with `cs_n_o`, `ras_n_o`, `cas_n_o` and `we_n_o` all 0. In every other cycle the outputs show NOP: `cs_n_o` = 0 and the other three = 1, with `ba_o` and `addr_o` at 0.
- R6: An accepted request is held while `banks_idle_i` is 0 or `burst_active_i` is 1. The strobe appears in the cycle after the first cycle in which the banks are idle and no burst is active.
- R7: `busy_o` rises in the cycle after a request is accepted. It stays high through TMRD cycles counted from the strobe cycle, and then falls. Two strobes are never closer than TMRD cycles apart.
- R8: A request with latency code 7, or with an OCD code other than 000 and 111 outside initialization, raises `err_o` for exactly one cycle. It issues no command and leaves `busy_o` at 0.
- R9: An initialization request issues two loads: first with OCD = 111, then with OCD = 000, and all other fields equal. The `ocd_i` input is ignored for this request, and the second strobe comes TMRD+1 cycles after the first when the banks are idle.
- R10: A request that arrives while `busy_o` is 1 is ignored. It causes no extra strobe and does not change the busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_req_i | input | 1 | Single-cycle request to load the register |
| ocd_init_i | input | 1 | With the request: run the OCD default-then-exit sequence |
| dll_off_i | input | 1 | Disable the DLL |
| drv_reduced_i | input | 1 | Use reduced output drive strength |
| odt_sel_i | input | 2 | Termination select |
| al_i | input | 3 | Additive latency, 0 to 6 |
| ocd_i | input | 3 | OCD mode for ordinary loads |
| dqsn_off_i | input | 1 | Disable the complementary strobe |
| rdqs_on_i | input | 1 | Enable the read strobe |
| out_off_i | input | 1 | Disable the outputs |
| banks_idle_i | input | 1 | All banks are idle |
| burst_active_i | input | 1 | A burst is in progress |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | 3 | Bank address (register select) |
| addr_o | output | ADDR_W | Address bus carrying the register word |
| busy_o | output | 1 | Request in progress, including the tMRD delay |
| err_o | output | 1 | One-cycle flag for a rejected request |

## Verification
The assertions check on every cycle that:
- only a NOP or a complete load command appears;
- a strobe lasts one cycle and follows a cycle with idle banks and no burst;
- strobes are at least TMRD apart;
- a load targets the extended register with legal latency and OCD codes;
- an error pulse is one cycle long, with no command and no busy.

Only the bench scenarios can show the exact placement of each field and of the termination pair, and the cycle in which a held request finally issues. They also show the length of the busy window, the order and contents of the two initialization loads, and that requests made while busy leave the output unchanged.

// File: rtl/emr_pkg.sv
package emr_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_DLY} seq_st_e;

  typedef struct packed {
    logic       out_off;
    logic       rdqs_on;
    logic       dqsn_off;
    logic [2:0] ocd;
    logic [2:0] al;
    logic [1:0] odt;
    logic       drv_red;
    logic       dll_off;
  } emr_cfg_t;

  localparam logic [2:0] OCD_EXIT = 3'b000;
  localparam logic [2:0] OCD_DFLT = 3'b111;
  localparam logic [2:0] AL_RSVD  = 3'b111;
  localparam logic [2:0] BA_EMR   = 3'b001;
  localparam int         EMR_USED_W = 13;
endpackage

// File: rtl/emr_req_check.sv
module emr_req_check
  import emr_pkg::*;
(
  input  logic [2:0] al_i,
  input  logic [2:0] ocd_i,
  input  logic       init_i,
  output logic       bad_o
);
  logic al_bad;
  logic ocd_bad;

  always_comb begin
    al_bad  = (al_i == AL_RSVD);
    ocd_bad = !init_i && (ocd_i != OCD_EXIT) && (ocd_i != OCD_DFLT);
    bad_o   = al_bad || ocd_bad;
  end
endmodule

// File: rtl/emr_word_pack.sv
module emr_word_pack
  import emr_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  emr_cfg_t          cfg_i,
  output logic [ADDR_W-1:0] word_o
);
  always_comb begin
    word_o      = '0;
    word_o[0]   = cfg_i.dll_off;
    word_o[1]   = cfg_i.drv_red;
    word_o[2]   = cfg_i.odt[0];
    word_o[5:3] = cfg_i.al;
    word_o[6]   = cfg_i.odt[1];
    word_o[9:7] = cfg_i.ocd;
    word_o[10]  = cfg_i.dqsn_off;
    word_o[11]  = cfg_i.rdqs_on;
    word_o[12]  = cfg_i.out_off;
  end
endmodule

// File: rtl/emr_mrd_timer.sv
module emr_mrd_timer #(
  parameter int TMRD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic zero_o
);
  localparam int CW = (TMRD > 1) ? $clog2(TMRD) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(TMRD - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)
      cnt_d = LOAD_VAL;
    else if (cnt_q != '0)
      cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/emr_loader.sv
module emr_loader
  import emr_pkg::*;
#(
  parameter int TMRD   = 4,
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_req_i,
  input  logic              ocd_init_i,
  input  logic              dll_off_i,
  input  logic              drv_reduced_i,
  input  logic [1:0]        odt_sel_i,
  input  logic [2:0]        al_i,
  input  logic [2:0]        ocd_i,
  input  logic              dqsn_off_i,
  input  logic              rdqs_on_i,
  input  logic              out_off_i,
  input  logic              banks_idle_i,
  input  logic              burst_active_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [2:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              busy_o,
  output logic              err_o
);
  logic [1:0] sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_i_n = sync_q[1];

  seq_st_e           state_q, state_d;
  emr_cfg_t          cfg_q, cfg_d;
  logic              cfg_en;
  logic              second_q, second_d;
  logic              strobe_q, strobe_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [2:0]        ba_q, ba_d;
  logic              err_q, err_d;
  logic              req_bad;
  logic              tmr_load;
  logic              tmr_zero;
  logic [ADDR_W-1:0] packed_word;
  logic              path_clear;

  emr_req_check u_check (
    .al_i   (al_i),
    .ocd_i  (ocd_i),
    .init_i (ocd_init_i),
    .bad_o  (req_bad)
  );

  emr_word_pack #(.ADDR_W(ADDR_W)) u_pack (
    .cfg_i  (cfg_q),
    .word_o (packed_word)
  );

  emr_mrd_timer #(.TMRD(TMRD)) u_timer (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .load_i (tmr_load),
    .zero_o (tmr_zero)
  );

  assign path_clear = banks_idle_i && !burst_active_i;

  always_comb begin
    state_d  = state_q;
    cfg_d    = cfg_q;
    cfg_en   = 1'b0;
    second_d = second_q;
    strobe_d = 1'b0;
    addr_d   = '0;
    ba_d     = '0;
    err_d    = 1'b0;
    tmr_load = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (load_req_i) begin
          if (req_bad) begin
            err_d = 1'b1;
          end else begin
            cfg_en         = 1'b1;
            cfg_d.dll_off  = dll_off_i;
            cfg_d.drv_red  = drv_reduced_i;
            cfg_d.odt      = odt_sel_i;
            cfg_d.al       = al_i;
            cfg_d.ocd      = ocd_init_i ? OCD_DFLT : ocd_i;
            cfg_d.dqsn_off = dqsn_off_i;
            cfg_d.rdqs_on  = rdqs_on_i;
            cfg_d.out_off  = out_off_i;
            second_d       = ocd_init_i;
            state_d        = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (path_clear) begin
          strobe_d = 1'b1;
          addr_d   = packed_word;
          ba_d     = BA_EMR;
          tmr_load = 1'b1;
          state_d  = ST_DLY;
        end
      end
      ST_DLY: begin
        if (tmr_zero) begin
          if (second_q) begin
            cfg_en    = 1'b1;
            cfg_d.ocd = OCD_EXIT;
            second_d  = 1'b0;
            state_d   = ST_WAIT;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q  <= ST_IDLE;
      cfg_q    <= '0;
      second_q <= 1'b0;
      strobe_q <= 1'b0;
      addr_q   <= '0;
      ba_q     <= '0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      if (cfg_en) cfg_q <= cfg_d;
      second_q <= second_d;
      strobe_q <= strobe_d;
      addr_q   <= addr_d;
      ba_q     <= ba_d;
      err_q    <= err_d;
    end
  end

  assign cs_n_o  = 1'b0;
  assign ras_n_o = !strobe_q;
  assign cas_n_o = !strobe_q;
  assign we_n_o  = !strobe_q;
  assign ba_o    = ba_q;
  assign addr_o  = addr_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign err_o   = err_q;
endmodule

// File: rtl/emr_loader_chk.sv
module emr_loader_chk #(
  parameter int TMRD   = 4,
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              banks_idle_i,
  input logic              burst_active_i,
  input logic              cs_n_o,
  input logic              ras_n_o,
  input logic              cas_n_o,
  input logic              we_n_o,
  input logic [2:0]        ba_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              busy_o,
  input logic              err_o
);
  localparam int SW = $clog2(TMRD + 1) + 1;

  logic          lmr;
  logic [SW-1:0] since_q;

  assign lmr = !cs_n_o && !ras_n_o && !cas_n_o && !we_n_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  since_q <= SW'(TMRD);
    else if (lmr)                since_q <= SW'(1);
    else if (since_q < SW'(TMRD)) since_q <= since_q + SW'(1);
  end

  p_cmd_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_o && ({ras_n_o, cas_n_o, we_n_o} == 3'b000 || {ras_n_o, cas_n_o, we_n_o} == 3'b111));

  p_strobe_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lmr |=> !lmr);

  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lmr |-> $past(banks_idle_i && !burst_active_i));

  p_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lmr |-> since_q >= SW'(TMRD));

  p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lmr |-> busy_o);

  p_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lmr |-> (ba_o == 3'b001) && ((addr_o >> 13) == '0));

  p_codes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lmr |-> (addr_o[5:3] != 3'b111) && (addr_o[9:7] == 3'b000 || addr_o[9:7] == 3'b111));

  p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);

  p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !lmr && !busy_o);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !lmr && (ba_o == 3'b000));
endmodule

bind emr_loader emr_loader_chk #(.TMRD(TMRD), .ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .banks_idle_i   (banks_idle_i),
  .burst_active_i (burst_active_i),
  .cs_n_o         (cs_n_o),
  .ras_n_o        (ras_n_o),
  .cas_n_o        (cas_n_o),
  .we_n_o         (we_n_o),
  .ba_o           (ba_o),
  .addr_o         (addr_o),
  .busy_o         (busy_o),
  .err_o          (err_o)
);

// File: tb/emr_loader_test.sv
`timescale 1ns/1ps
module emr_loader_test;
  localparam int TMRD   = 4;
  localparam int ADDR_W = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_req, ocd_init, dll_off, drv_red, dqsn_off, rdqs_on, out_off;
  logic [1:0] odt;
  logic [2:0] al, ocd;
  logic banks_idle, burst_act;
  logic cs_n, ras_n, cas_n, we_n, busy, err;
  logic [2:0] ba;
  logic [ADDR_W-1:0] addr;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  emr_loader #(.TMRD(TMRD), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .load_req_i(load_req), .ocd_init_i(ocd_init),
    .dll_off_i(dll_off), .drv_reduced_i(drv_red), .odt_sel_i(odt), .al_i(al),
    .ocd_i(ocd), .dqsn_off_i(dqsn_off), .rdqs_on_i(rdqs_on), .out_off_i(out_off),
    .banks_idle_i(banks_idle), .burst_active_i(burst_act),
    .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .ba_o(ba), .addr_o(addr), .busy_o(busy), .err_o(err)
  );

  function automatic bit is_lmr();
    return !cs_n && !ras_n && !cas_n && !we_n;
  endfunction

  function automatic bit is_nop();
    return !cs_n && ras_n && cas_n && we_n && ba == 3'd0 && addr == '0;
  endfunction

  function automatic int exp_word(input int ocd_v);
    return int'(dll_off) + 2 * int'(drv_red) + 4 * int'(odt[0]) + 8 * int'(al)
         + 64 * int'(odt[1]) + 128 * ocd_v + 1024 * int'(dqsn_off)
         + 2048 * int'(rdqs_on) + 4096 * int'(out_off);
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Strobe cycle: checks command, target and word (R2 R3 R4 R5)
  task automatic check_strobe(input int ocd_v, input string rq);
    int ew;
    ew = exp_word(ocd_v);
    check(is_lmr(), "R5", {rq, " load strobe"}, {ras_n, cas_n, we_n}, 0);
    check(int'(addr) == ew, "R2", {rq, " word"}, int'(addr), ew);
    check(addr[6] == odt[1] && addr[2] == odt[0], "R3", "termination pair",
          {addr[6], addr[2]}, odt);
    check(ba == 3'b001, "R4", "bank select", ba, 1);
  endtask

  // Cycles after strobe: busy for TMRD cycles including strobe cycle (R7)
  task automatic check_delay(input bit last);
    for (int k = 1; k < TMRD; k++) begin
      @(negedge clk);
      check(busy && is_nop(), "R7", "busy nop during delay", busy, 1);
    end
    @(negedge clk);
    if (last) check(!busy && is_nop(), "R7", "busy falls after delay", busy, 0);
    else      check(busy && is_nop(), "R9", "busy held between init loads", busy, 1);
  endtask

  task automatic do_load(input bit init);
    @(negedge clk);
    load_req = 1'b1; ocd_init = init;
    @(negedge clk);
    load_req = 1'b0;
    check(busy && is_nop(), "R7", "busy after accept", busy, 1);
    @(negedge clk);
    check_strobe(init ? 7 : int'(ocd), init ? "R9" : "R2");
    if (init) begin
      check_delay(1'b0);
      @(negedge clk);
      check_strobe(0, "R9");
    end
    check_delay(1'b1);
    ocd_init = 1'b0;
  endtask

  task automatic do_reject(input string rq);
    @(negedge clk);
    load_req = 1'b1;
    @(negedge clk);
    load_req = 1'b0;
    check(err && !busy && is_nop(), rq, "error pulse", err, 1);
    @(negedge clk);
    check(!err && !busy && is_nop(), rq, "error one cycle, no load", err, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    load_req = 0; ocd_init = 0; dll_off = 0; drv_red = 0; odt = 0; al = 0; ocd = 0;
    dqsn_off = 0; rdqs_on = 0; out_off = 0; banks_idle = 1; burst_act = 0;
    repeat (3) @(negedge clk);
    check(is_nop() && !busy && !err, "R1", "in reset", busy, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(is_nop() && !busy && !err, "R1", "after reset", busy, 0);

    // R2 R3 sweep of latency, termination and single-bit fields
    for (int a = 0; a < 7; a++) begin
      for (int t = 0; t < 4; t++) begin
        int i;
        i = a * 4 + t + 3 * a;
        al = 3'(a); odt = 2'(t);
        dll_off = i[0]; drv_red = i[1]; dqsn_off = i[2]; rdqs_on = i[3];
        out_off = i[4]; ocd = i[5] ? 3'b111 : 3'b000;
        do_load(1'b0);
      end
    end

    // R6 held while banks busy, then while burst active
    al = 3'd2; odt = 2'b10; ocd = 3'b000; dll_off = 1; out_off = 0;
    banks_idle = 1'b0;
    @(negedge clk); load_req = 1'b1;
    @(negedge clk); load_req = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(busy && is_nop(), "R6", "held while banks not idle", ras_n, 1);
    end
    banks_idle = 1'b1; burst_act = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(busy && is_nop(), "R6", "held while burst active", ras_n, 1);
    end
    burst_act = 1'b0;
    @(negedge clk);
    check_strobe(0, "R6");
    check_delay(1'b1);

    // R9 init sequence, ocd_i ignored
    al = 3'd5; odt = 2'b11; rdqs_on = 1; ocd = 3'b011;
    do_load(1'b1);
    ocd = 3'b000;

    // R10 requests during busy ignored
    al = 3'd1; odt = 2'b01;
    @(negedge clk); load_req = 1'b1;
    @(negedge clk); load_req = 1'b0;
    @(negedge clk);
    check_strobe(0, "R10");
    al = 3'd6; odt = 2'b00; dll_off = ~dll_off;
    load_req = 1'b1;
    @(negedge clk); load_req = 1'b0;
    check(busy && is_nop(), "R10", "no reaction while busy", ras_n, 1);
    for (int k = 2; k < TMRD; k++) begin
      @(negedge clk);
      check(busy && is_nop(), "R10", "busy window unchanged", busy, 1);
    end
    @(negedge clk);
    check(!busy && is_nop(), "R10", "busy ends on time", busy, 0);
    repeat (3) begin
      @(negedge clk);
      check(!busy && is_nop(), "R10", "no late load", ras_n, 1);
    end

    // R8 reserved codes
    al = 3'd7; ocd = 3'b000; do_reject("R8");
    ocd_init = 1'b1; do_reject("R8"); ocd_init = 1'b0;
    al = 3'd0;
    for (int c = 1; c < 7; c++) begin
      ocd = 3'(c);
      do_reject("R8");
    end
    ocd = 3'b000;
    do_load(1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule